// File: doc/BRIEF.md
# ASCII Hex Record Loader

This block turns a stream of ASCII characters into memory writes. A character source, typically a serial receiver, presents one character per cycle in which its strobe is high. The loader finds the start of each text record, decodes the hexadecimal fields that follow, and sends every payload byte to a memory write port as an address, a data byte and a one-cycle write enable.

Every record carries its own checksum. A record whose checksum does not balance produces an error pulse. So does any character that is not a hex digit inside a record, and so does a record type that the loader does not support. After any of these the loader goes back to looking for the next record. An end-of-file record with a good checksum raises a done flag, which stays high until reset. Text between records is skipped, including line breaks and stray characters.

Top module: `hexrec_loader`

## Requirements
- R1: Outside a record, every character other than the colon (0x3A) is ignored. This includes CR, LF, letters and hex digits: none of them causes a write or an error pulse.
- R2: After the colon, the record fields come in this order, each as ASCII hex digits with the most significant nibble first:
  - a byte count (2 digits);
  - a 16-bit base address (4 digits);
  - a type byte (2 digits);
  - the payload bytes (2 digits each);
  - a checksum byte (2 digits).
- R3: In a type 0x00 record, payload byte k is written to base address + k, with exactly one `wr_en` pulse per byte. That pulse is in the cycle after the byte's second digit is accepted.
- R4: Hex letters A to F are accepted in both upper and lower case, with equal value.
- R5: A checksum is good when the 8-bit sum of all record bytes, from the count through the checksum, is zero. A record with a bad checksum gives a one-cycle `error` pulse in the cycle after its last digit.
- R6: Inside a record, a character that is not a hex digit gives a one-cycle `error` pulse. The loader then waits for a new colon, and the following record is decoded normally.
- R7: A type 0x01 record with a good checksum sets `done` in the cycle after its last digit. Such a record causes no write, and `done` stays high until reset.
- R8: A type byte other than 0x00 or 0x01 gives one `error` pulse when the type is decoded. The rest of that record is ignored.
- R9: While `rst` is high and after its release, `wr_en`, `error` and `done` are 0.
- R10: A type 0x00 record with a count of zero and a good checksum causes no write and no error.
- R11: Write addresses wrap modulo 2^16: base 0xFFFE plus offset 2 gives address 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_valid | input | 1 | Strobe: `char_data` holds a character this cycle |
| char_data | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle memory write enable |
| wr_addr | output | 16 | Memory write address |
| wr_data | output | 8 | Memory write data |
| done | output | 1 | End-of-file record seen; held until reset |
| error | output | 1 | One-cycle pulse on a bad character, an unknown type or a bad checksum |

## Verification
The assertions assume that `char_valid` is low while `rst` is high, and that a write, an error pulse or a rise of `done` can only follow a cycle in which a character was accepted. The bench holds the strobe low during reset. It sends each character as a single-cycle strobe followed by one idle cycle. Its random filler between records never contains a colon, so every colon the loader sees is a real record start. Random records draw their address, payload, letter case and corrupted checksums from a fixed-seed generator. Directed cases cover address wrap, zero-length records, unknown types, stray characters inside a record and the end-of-file flag.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    localparam int BYTE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int ADDR_W     = 16;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;

    localparam logic [BYTE_W-1:0] CH_COLON  = 8'h3A;
    localparam logic [BYTE_W-1:0] TYPE_DATA = 8'h00;
    localparam logic [BYTE_W-1:0] TYPE_EOF  = 8'h01;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_ADDR,
        ST_TYPE,
        ST_DATA,
        ST_CSUM
    } fld_e;

    typedef struct packed {
        logic             is_hex;
        logic             is_colon;
        logic [NIB_W-1:0] nib;
    } char_info_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic char_info_t classify(input logic [BYTE_W-1:0] c);
        char_info_t ci;
        ci          = '0;
        ci.is_colon = (c == CH_COLON);
        if (c >= 8'h30 && c <= 8'h39) begin
            ci.is_hex = 1'b1;
            ci.nib    = c[NIB_W-1:0];
        end else if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66)) begin
            ci.is_hex = 1'b1;
            ci.nib    = c[NIB_W-1:0] + 4'd9;
        end
        return ci;
    endfunction

endpackage

// File: rtl/hexrec_char_decode.sv
module hexrec_char_decode
    import hexrec_pkg::*;
(
    input  logic [BYTE_W-1:0] ch,
    output char_info_t        info
);
    assign info = classify(ch);
endmodule

// File: rtl/hexrec_byte_pack.sv
module hexrec_byte_pack
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              nib_vld,
    input  logic [NIB_W-1:0]  nib,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val
);
    logic             phase_q;
    logic [NIB_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= 1'b0;
            hi_q    <= '0;
        end else if (nib_vld) begin
            phase_q <= ~phase_q;
            if (!phase_q) hi_q <= nib;
        end
    end

    assign byte_vld = nib_vld & phase_q;
    assign byte_val = {hi_q, nib};
endmodule

// File: rtl/hexrec_sum.sv
module hexrec_sum
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_vld,
    input  logic [BYTE_W-1:0] add_val,
    output logic [BYTE_W-1:0] sum_q
);
    always_ff @(posedge clk) begin
        if (rst || clr)   sum_q <= '0;
        else if (add_vld) sum_q <= sum_q + add_val;
    end
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              char_valid,
    input  logic [BYTE_W-1:0] char_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              done,
    output logic              error
);
    localparam int CNT_W  = BYTE_W;
    localparam int OFS_PD = ADDR_W - CNT_W;
    localparam int AIDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    char_info_t        info;
    fld_e              state_q;
    logic              in_rec, start, bad_char, nib_vld;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val, sum_q, sum_next;
    logic [CNT_W-1:0]  len_q, cnt_q;
    logic [ADDR_W-1:0] base_q;
    logic [BYTE_W-1:0] type_q;
    logic [AIDX_W-1:0] aidx_q;
    wr_req_t           wr_q;
    logic              done_q, err_q;

    hexrec_char_decode u_dec (.ch(char_data), .info(info));

    assign in_rec   = (state_q != ST_HUNT);
    assign start    = char_valid & ~in_rec & info.is_colon;
    assign bad_char = char_valid & in_rec & ~info.is_hex;
    assign nib_vld  = char_valid & in_rec & info.is_hex;

    hexrec_byte_pack u_pack (
        .clk(clk), .rst(rst), .clr(start | bad_char),
        .nib_vld(nib_vld), .nib(info.nib),
        .byte_vld(byte_vld), .byte_val(byte_val)
    );

    hexrec_sum u_sum (
        .clk(clk), .rst(rst), .clr(start),
        .add_vld(byte_vld), .add_val(byte_val), .sum_q(sum_q)
    );

    assign sum_next = sum_q + byte_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            len_q   <= '0;
            cnt_q   <= '0;
            base_q  <= '0;
            type_q  <= '0;
            aidx_q  <= '0;
            wr_q    <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            wr_q.en <= 1'b0;
            err_q   <= 1'b0;
            if (start) begin
                state_q <= ST_LEN;
            end else if (bad_char) begin
                err_q   <= 1'b1;
                state_q <= ST_HUNT;
            end else if (byte_vld) begin
                unique case (state_q)
                    ST_LEN: begin
                        len_q   <= byte_val;
                        aidx_q  <= '0;
                        state_q <= ST_ADDR;
                    end
                    ST_ADDR: begin
                        base_q <= {base_q[ADDR_W-BYTE_W-1:0], byte_val};
                        aidx_q <= aidx_q + AIDX_W'(1);
                        if (aidx_q == AIDX_W'(ADDR_BYTES - 1)) state_q <= ST_TYPE;
                    end
                    ST_TYPE: begin
                        type_q <= byte_val;
                        cnt_q  <= '0;
                        if (byte_val == TYPE_DATA || byte_val == TYPE_EOF) begin
                            state_q <= (len_q == '0) ? ST_CSUM : ST_DATA;
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= ST_HUNT;
                        end
                    end
                    ST_DATA: begin
                        if (type_q == TYPE_DATA) begin
                            wr_q.en   <= 1'b1;
                            wr_q.addr <= base_q + {{OFS_PD{1'b0}}, cnt_q};
                            wr_q.data <= byte_val;
                        end
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q + CNT_W'(1) == len_q) state_q <= ST_CSUM;
                    end
                    ST_CSUM: begin
                        if (sum_next == '0) begin
                            if (type_q == TYPE_EOF) done_q <= 1'b1;
                        end else begin
                            err_q <= 1'b1;
                        end
                        state_q <= ST_HUNT;
                    end
                    default: state_q <= ST_HUNT;
                endcase
            end
        end
    end

    assign wr_en   = wr_q.en;
    assign wr_addr = wr_q.addr;
    assign wr_data = wr_q.data;
    assign done    = done_q;
    assign error   = err_q;
endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk (
    input logic clk,
    input logic rst,
    input logic char_valid,
    input logic wr_en,
    input logic done,
    input logic error
);
    // R7: done holds until reset
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R3: each write follows an accepted character
    p_wr_after_char_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(char_valid));

    // R5, R6, R8: error pulses follow an accepted character
    p_err_after_char_r5: assert property (@(posedge clk) disable iff (rst)
        error |-> $past(char_valid));

    // R7: done rises only on a character
    p_done_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(char_valid));

    // R6: write and error never in the same cycle
    p_no_wr_with_err_r6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && error));

    // R9: outputs clear while in reset
    always @(posedge clk) begin
        if ($past(rst) && rst) begin
            p_reset_quiet_r9: assert (!wr_en && !error && !done);
        end
    end
endmodule

bind hexrec_loader hexrec_loader_chk u_chk (
    .clk(clk), .rst(rst), .char_valid(char_valid),
    .wr_en(wr_en), .done(done), .error(error)
);

// File: tb/hexrec_loader_bench.sv
`timescale 1ns/1ps
module hexrec_loader_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        char_valid = 1'b0;
    logic [7:0]  char_data = 8'h00;
    logic        wr_en, done, error;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0]  pay [0:255];
    logic [15:0] got_a [0:255];
    logic [7:0]  got_d [0:255];
    int got_n = 0;
    int err_seen = 0;

    always #2.5 clk = ~clk;

    hexrec_loader u_hexrec_loader (
        .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .error(error)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en && got_n < 256) begin
                got_a[got_n] = wr_addr;
                got_d[got_n] = wr_data;
                got_n++;
            end
            if (error) err_seen++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] n, input bit lc);
        if (n < 4'd10) return 8'h30 + {4'b0, n};
        return (lc ? 8'h61 : 8'h41) + {4'b0, n} - 8'd10;
    endfunction

    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        char_valid = 1'b1;
        char_data  = c;
        @(negedge clk);
        char_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit lc);
        send_char(hexch(b[7:4], lc));
        send_char(hexch(b[3:0], lc));
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] rec_csum(input int len, input logic [15:0] a,
                                            input logic [7:0] t);
        logic [7:0] s;
        s = 8'(len) + a[15:8] + a[7:0] + t;
        for (int i = 0; i < len; i++) s = s + pay[i];
        return 8'd0 - s;
    endfunction

    task automatic send_rec(input int len, input logic [15:0] a, input logic [7:0] t,
                            input bit bad, input bit lc);
        logic [7:0] cs;
        cs = rec_csum(len, a, t);
        if (bad) cs = cs ^ 8'h01;
        send_char(8'h3A);
        send_byte(8'(len), lc);
        send_byte(a[15:8], lc);
        send_byte(a[7:0], lc);
        send_byte(t, lc);
        for (int i = 0; i < len; i++) send_byte(pay[i], lc);
        send_byte(cs, lc);
        settle();
    endtask

    task automatic expect_rec(input string req, input int len, input logic [15:0] a,
                              input int exp_err, input int err0);
        bit ok;
        ok = 1;
        chk(got_n == len, req, "write count", got_n, len);
        for (int i = 0; i < len && i < got_n; i++) begin
            if (got_a[i] != a + 16'(i) || got_d[i] != pay[i]) ok = 0;
        end
        chk(ok, req, "write addr/data (R2 R3)", 0, 0);
        chk(err_seen - err0 == exp_err, req, "error pulses", err_seen - err0, exp_err);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int e0;
        logic [7:0] junk [0:6];
        void'($urandom(32'h5EED_1234));
        junk[0] = 8'h0D; junk[1] = 8'h0A; junk[2] = 8'h47; junk[3] = 8'h7A;
        junk[4] = 8'h20; junk[5] = 8'h35; junk[6] = 8'h41;

        repeat (3) @(negedge clk);
        chk(!wr_en && !error && !done, "R9", "outputs in reset", {wr_en, error, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_en && !error && !done, "R9", "outputs after reset", {wr_en, error, done}, 0);

        // R1: junk outside records
        got_n = 0; e0 = err_seen;
        for (int i = 0; i < 7; i++) send_char(junk[i]);
        settle();
        chk(got_n == 0 && err_seen == e0, "R1", "junk ignored", got_n + err_seen - e0, 0);

        // R4: mixed case directed record
        got_n = 0; e0 = err_seen;
        pay[0] = 8'hAB; pay[1] = 8'hcd; pay[2] = 8'hEf;
        send_rec(3, 16'hBeEF, 8'h00, 0, 1);
        expect_rec("R4", 3, 16'hBEEF, 0, e0);

        // R11: address wrap
        got_n = 0; e0 = err_seen;
        for (int i = 0; i < 4; i++) pay[i] = 8'(8'h10 + i);
        send_rec(4, 16'hFFFE, 8'h00, 0, 0);
        expect_rec("R11", 4, 16'hFFFE, 0, e0);
        chk(got_a[2] == 16'h0000, "R11", "wrapped address", got_a[2], 0);

        // R10: zero-length record
        got_n = 0; e0 = err_seen;
        send_rec(0, 16'h1234, 8'h00, 0, 0);
        expect_rec("R10", 0, 16'h1234, 0, e0);

        // R6: non-hex inside record, then recovery
        got_n = 0; e0 = err_seen;
        send_char(8'h3A); send_byte(8'h02, 0); send_char(8'h78);
        settle();
        chk(err_seen - e0 == 1, "R6", "bad char error", err_seen - e0, 1);
        got_n = 0; e0 = err_seen;
        pay[0] = 8'h5A; pay[1] = 8'hA5;
        send_rec(2, 16'h0040, 8'h00, 0, 0);
        expect_rec("R6", 2, 16'h0040, 0, e0);

        // R8: unsupported type, rest ignored
        got_n = 0; e0 = err_seen;
        pay[0] = 8'h11; pay[1] = 8'h22;
        send_rec(2, 16'h0100, 8'h02, 0, 0);
        chk(err_seen - e0 == 1, "R8", "unknown type error", err_seen - e0, 1);
        chk(got_n == 0, "R8", "no writes", got_n, 0);

        // R5: directed bad checksum
        got_n = 0; e0 = err_seen;
        pay[0] = 8'h99;
        send_rec(1, 16'h2000, 8'h00, 1, 0);
        expect_rec("R5", 1, 16'h2000, 1, e0);

        // R7: bad EOF does not set done, good one does
        got_n = 0; e0 = err_seen;
        send_rec(0, 16'h0000, 8'h01, 1, 0);
        chk(!done && err_seen - e0 == 1, "R7", "bad EOF", {done, 1'b0}, 0);
        got_n = 0; e0 = err_seen;
        send_rec(0, 16'h0000, 8'h01, 0, 0);
        chk(done == 1'b1, "R7", "done set", done, 1);
        chk(got_n == 0 && err_seen == e0, "R7", "EOF quiet", got_n, 0);
        pay[0] = 8'h77;
        got_n = 0; e0 = err_seen;
        send_rec(1, 16'h3000, 8'h00, 0, 0);
        chk(done == 1'b1, "R7", "done held", done, 1);
        expect_rec("R3", 1, 16'h3000, 0, e0);
        do_reset();
        chk(!done, "R9", "done cleared by reset", done, 0);

        // random records with junk between them
        for (int r = 0; r < 40; r++) begin
            int len;
            bit bad, lc;
            logic [15:0] a;
            len = int'($urandom_range(0, 8));
            a   = 16'($urandom);
            bad = ($urandom_range(0, 4) == 0);
            lc  = $urandom_range(0, 1) == 1;
            for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
            for (int j = 0; j < int'($urandom_range(0, 3)); j++)
                send_char(junk[$urandom_range(0, 6)]);
            got_n = 0; e0 = err_seen;
            send_rec(len, a, 8'h00, bad, lc);
            expect_rec(bad ? "R5" : "R3", len, a, bad ? 1 : 0, e0);
        end
        chk(!done, "R7", "done stays low without EOF", done, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule